// File: doc/BRIEF.md
# Outbound Window Address Translator

This block sits on the outbound path of a PCIe root-complex controller and maps CPU-side addresses that fall inside a fixed outbound aperture onto 64-bit PCIe bus addresses. The aperture is split into a row of equal-sized windows. A 3-bit power-of-two index sets the size of every window. Each window carries its own 64-bit bus base and its own enable bit.

Software programs the block through a small word-addressed register port. That port holds a command register with a global translation enable, the window-size index, and a low/high base pair for every window. Each translation request is one address with a valid strobe. One clock later the block returns either the translated bus address or an error flag with a zero address. An error is returned when the address lies outside the windows, when the selected window is disabled, or when translation is globally off. A change to the size index applies only to requests presented in later cycles.

Top module: `ob_xlat`

## Requirements
- R1: After reset the command register, the size index and every window base register read back as zero, and `rsp_valid` is low.
- R2: The size index is register bits [2:0] at offset 0x030. The window size is 2^index MiB, so index 3 gives 8 MiB. The upper bits are not stored and read back as zero.
- R3: For an address A at or above `APERTURE_BASE`, the selected window is (A − APERTURE_BASE) / window size.
- R4: On a hit, `rsp_addr` is the 64-bit value {high register, low register with bit 0 forced to zero} plus (A − APERTURE_BASE) modulo the window size. `rsp_err` is low.
- R5: Window n has its low register at offset 0x200+8n and its high register at 0x204+8n. Bit 0 of the low register enables the window. A request that selects a disabled window returns `rsp_err` high and `rsp_addr` zero.
- R6: Bit 1 of the command register at offset 0x004 is the global translation enable, and it is the only stored bit there. While it is zero, every request returns `rsp_err` high and `rsp_addr` zero.
- R7: A request below `APERTURE_BASE`, or one whose window number is `NUM_WIN` or more, returns `rsp_err` high and `rsp_addr` zero.
- R8: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high.
- R9: A request presented in the same cycle as a write to the size index is translated with the old size. Requests in later cycles use the new size.
- R10: Registers read back as written, through a combinational read on `reg_rdata`. Addresses that map to no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | CPU address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 64 | Translated bus address, zero on error |
| rsp_err | output | 1 | Miss or disabled indication |

## Verification
The bench sweeps all eight size indices. For each index it probes the first, an interior and the last byte of every window, plus two window positions past the end.

Each probe catches a particular fault:
- A wrong shift would move the last byte into the next window.
- A carry dropped in the 64-bit add would corrupt the high half.
- An unmasked enable bit would leak into the bus address as an odd value.

Disabled windows, an address just below the base and the global-off state must all return an error with a zero address. A design that only suppressed the address, or only raised the flag, fails these probes. A request issued alongside a size write would expose a size path that bypasses its register and so picks the wrong window.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  localparam int REG_AW        = 12;
  localparam int MIB_SHIFT     = 20;
  localparam int SIZE_W        = 3;
  localparam logic [REG_AW-1:0] OFS_CMD  = 12'h004;
  localparam logic [REG_AW-1:0] OFS_SIZE = 12'h030;
  localparam logic [REG_AW-1:0] OFS_WIN  = 12'h200;
  localparam int GLOBAL_EN_BIT = 1;
  localparam int WIN_EN_BIT    = 0;
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         xlat_en,
  output logic [SIZE_W-1:0]            size_idx,
  output logic [NUM_WIN-1:0][31:0]     win_lo,
  output logic [NUM_WIN-1:0][31:0]     win_hi
);
  localparam int IDX_W = $clog2(NUM_WIN);

  logic [REG_AW-1:0] win_rel;
  logic              hit_cmd, hit_size, hit_win, sel_hi;
  logic [IDX_W-1:0]  win_num;
  logic              cmd_q, cmd_d;
  logic [SIZE_W-1:0] size_q, size_d;

  // address decode
  always_comb begin
    win_rel  = reg_addr - OFS_WIN;
    hit_cmd  = (reg_addr == OFS_CMD);
    hit_size = (reg_addr == OFS_SIZE);
    hit_win  = (reg_addr >= OFS_WIN) && (reg_addr[1:0] == 2'b00) &&
               ((32'(win_rel) >> 3) < NUM_WIN);
    win_num  = win_rel[IDX_W+2:3];
    sel_hi   = win_rel[2];
  end

  // next state for global registers
  always_comb begin
    cmd_d  = cmd_q;
    size_d = size_q;
    if (reg_wr && hit_cmd)  cmd_d  = reg_wdata[GLOBAL_EN_BIT];
    if (reg_wr && hit_size) size_d = reg_wdata[SIZE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      size_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      size_q <= size_d;
    end
  end

  // per-window base registers
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    logic        lo_ce, hi_ce;
    logic [31:0] lo_q, hi_q;
    assign lo_ce = reg_wr && hit_win && (win_num == IDX_W'(n)) && !sel_hi;
    assign hi_ce = reg_wr && hit_win && (win_num == IDX_W'(n)) &&  sel_hi;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_ce) lo_q <= reg_wdata;
        if (hi_ce) hi_q <= reg_wdata;
      end
    end
    assign win_lo[n] = lo_q;
    assign win_hi[n] = hi_q;
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_cmd)       reg_rdata[GLOBAL_EN_BIT] = cmd_q;
    else if (hit_size) reg_rdata[SIZE_W-1:0]    = size_q;
    else if (hit_win)  reg_rdata = sel_hi ? win_hi[win_num] : win_lo[win_num];
  end

  assign xlat_en  = cmd_q;
  assign size_idx = size_q;

  // R2: size index changes only through a write to its offset
  p_size_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && hit_size) |=> $stable(size_idx));
  // R6: global enable changes only through a command write
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && hit_cmd) |=> $stable(xlat_en));
endmodule

// File: rtl/ob_xlat_lookup.sv
module ob_xlat_lookup
  import ob_xlat_pkg::*;
#(
  parameter int          NUM_WIN       = 32,
  parameter int          ADDR_W        = 32,
  parameter logic [31:0] APERTURE_BASE = 32'h5000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     xlat_en,
  input  logic [SIZE_W-1:0]        size_idx,
  input  logic [NUM_WIN-1:0][31:0] win_lo,
  input  logic [NUM_WIN-1:0][31:0] win_hi,
  output logic                     rsp_valid,
  output logic [63:0]              rsp_addr,
  output logic                     rsp_err
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(APERTURE_BASE);

  logic [ADDR_W:0]   rel;
  logic              below;
  logic [5:0]        shamt;
  logic [ADDR_W-1:0] win_full, off_mask, off;
  logic              in_range, hit;
  logic [IDX_W-1:0]  sel;
  logic [31:0]       lo_sel, hi_sel;
  logic [63:0]       addr_d;
  logic              err_d;

  always_comb begin
    rel      = {1'b0, req_addr} - BASE_X;
    below    = rel[ADDR_W];
    shamt    = 6'(MIB_SHIFT) + 6'(size_idx);
    win_full = rel[ADDR_W-1:0] >> shamt;
    off_mask = (ADDR_W'(1) << shamt) - ADDR_W'(1);
    off      = rel[ADDR_W-1:0] & off_mask;
    in_range = !below && (win_full < ADDR_W'(NUM_WIN));
    sel      = win_full[IDX_W-1:0];
    lo_sel   = win_lo[sel];
    hi_sel   = win_hi[sel];
    hit      = xlat_en && in_range && lo_sel[WIN_EN_BIT];
    addr_d   = hit ? ({hi_sel, lo_sel[31:1], 1'b0} + 64'(off)) : 64'd0;
    err_d    = !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= addr_d;
        rsp_err  <= err_d;
      end
    end
  end

  // R8: one response per request, one cycle later
  p_rsp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R5: an error never carries an address
  p_err_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_addr == 64'd0));
  // R7: below the aperture is always an error
  p_below_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr < ADDR_W'(APERTURE_BASE))) |=> rsp_err);
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
  import ob_xlat_pkg::*;
#(
  parameter int          NUM_WIN       = 32,
  parameter int          ADDR_W        = 32,
  parameter logic [31:0] APERTURE_BASE = 32'h5000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [63:0]       rsp_addr,
  output logic              rsp_err
);
  logic [1:0]               rst_sync;
  logic                     rst_n_i;
  logic                     xlat_en;
  logic [SIZE_W-1:0]        size_idx;
  logic [NUM_WIN-1:0][31:0] win_lo, win_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  ob_xlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .xlat_en(xlat_en), .size_idx(size_idx),
    .win_lo(win_lo), .win_hi(win_hi)
  );

  ob_xlat_lookup #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .APERTURE_BASE(APERTURE_BASE)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n_i),
    .req_valid(req_valid), .req_addr(req_addr),
    .xlat_en(xlat_en), .size_idx(size_idx),
    .win_lo(win_lo), .win_hi(win_hi),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  // R6: globally disabled translation yields an error
  p_global_off_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !xlat_en) |=> (rsp_valid && rsp_err));
endmodule

// File: tb/ob_xlat_bench.sv
module ob_xlat_bench;
  localparam logic [31:0] BASE = 32'h5000_0000;
  localparam int NW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        rsp_err;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] lo_s [NW];
  logic [31:0] hi_s [NW];
  bit          gen_s;
  int          sz_s;

  always #2 clk = ~clk;

  ob_xlat u_ob_xlat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === e, tag, 64'(reg_rdata), 64'(e));
  endtask

  task automatic req(input logic [31:0] a, output bit err, output logic [63:0] ba);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R8 rsp_valid after req", 64'(rsp_valid), 64'd1);
    err = rsp_err; ba = rsp_addr;
  endtask

  // model of the translation, from the requirements
  task automatic model(input logic [31:0] a, input int sz, output bit err,
                       output logic [63:0] ba, output string tag);
    longint unsigned rel, ws, w;
    err = 1'b1; ba = 64'd0; tag = "R7 below base";
    if (a < BASE) return;
    rel = 64'(a) - 64'(BASE);
    ws  = 64'd1 << (20 + sz);
    w   = rel / ws;
    tag = "R7 beyond last window";
    if (w >= NW) return;
    tag = "R6 global off";
    if (!gen_s) return;
    tag = "R5 disabled window";
    if (!lo_s[w][0]) return;
    tag = "R3/R4 hit";
    err = 1'b0;
    ba  = {hi_s[w], lo_s[w][31:1], 1'b0} + (rel % ws);
  endtask

  task automatic probe(input logic [31:0] a);
    bit e_err, g_err;
    logic [63:0] e_ba, g_ba;
    string tag;
    model(a, sz_s, e_err, e_ba, tag);
    req(a, g_err, g_ba);
    chk(g_err === e_err, {tag, " err"}, 64'(g_err), 64'(e_err));
    chk(g_ba === e_ba, {tag, " addr"}, g_ba, e_ba);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit g_err;
    logic [63:0] g_ba;
    longint unsigned ws, a64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    rd_chk(12'h004, 32'h0, "R1 cmd");
    rd_chk(12'h030, 32'h0, "R1 size");
    rd_chk(12'h200, 32'h0, "R1 win0 lo");
    rd_chk(12'h2FC, 32'h0, "R1 win31 hi");
    gen_s = 1'b0; sz_s = 0;
    for (int n = 0; n < NW; n++) begin lo_s[n] = '0; hi_s[n] = '0; end

    // R6 off after reset
    probe(BASE + 32'h100);

    // program windows, two left disabled
    for (int n = 0; n < NW; n++) begin
      lo_s[n] = 32'h8000_0000 + 32'(n) * 32'h0300_0000 + ((n == 5 || n == 17) ? 32'h0 : 32'h1);
      hi_s[n] = 32'h0000_0100 + 32'(n);
      if (n == 30) lo_s[n] = 32'hFFF0_0001; // forces a carry into the high word
      wr(12'h200 + 12'(8*n), lo_s[n]);
      wr(12'h204 + 12'(8*n), hi_s[n]);
    end
    rd_chk(12'h228, lo_s[5], "R10 win5 lo");
    rd_chk(12'h2F4, hi_s[30], "R10 win30 hi");
    rd_chk(12'h100, 32'h0, "R10 unmapped");
    rd_chk(12'h202, 32'h0, "R10 misaligned");

    // R6 only bit1 stored
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk(12'h004, 32'h2, "R6 cmd readback");
    gen_s = 1'b1;

    // sweep every size index
    for (int s = 0; s < 8; s++) begin
      wr(12'h030, 32'hFFFF_FFF8 | 32'(s));
      rd_chk(12'h030, 32'(s), "R2 size readback");
      sz_s = s;
      ws = 64'd1 << (20 + s);
      for (int w = 0; w < NW + 2; w++) begin
        for (int p = 0; p < 3; p++) begin
          a64 = 64'(BASE) + longint'(w) * ws + ((p == 0) ? 64'd0 : (p == 1) ? (ws / 3) : (ws - 1));
          if (a64 < 64'h1_0000_0000) probe(a64[31:0]);
        end
      end
    end

    // R7 just below the aperture
    probe(BASE - 32'h1);

    // R6 global off blocks a valid window
    sz_s = 0;
    wr(12'h030, 32'h0);
    wr(12'h004, 32'h0);
    gen_s = 1'b0;
    probe(BASE + 32'h0010_0004);
    wr(12'h004, 32'h2);
    gen_s = 1'b1;

    // R9 size write in the same cycle as a request
    wr(12'h030, 32'h3);
    sz_s = 3;
    begin
      bit e_err; logic [63:0] e_ba; string tag;
      model(BASE + 32'h0090_0010, 3, e_err, e_ba, tag);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 12'h030; reg_wdata = 32'h0;
      req_valid = 1'b1; req_addr = BASE + 32'h0090_0010;
      @(negedge clk);
      reg_wr = 1'b0; req_valid = 1'b0;
      chk(rsp_addr === e_ba && rsp_err === e_err, "R9 old size used", rsp_addr, e_ba);
      // R8 no response without request
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R8 no spurious rsp", 64'(rsp_valid), 0);
      sz_s = 0;
      model(BASE + 32'h0090_0010, 0, e_err, e_ba, tag);
      req(BASE + 32'h0090_0010, g_err, g_ba);
      chk(g_ba === e_ba && g_err === e_err, "R9 new size used", g_ba, e_ba);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule